// File: doc/BRIEF.md
# Dual-Set Host Interrupt Controller

This block merges two independent groups of interrupt state into a single host interrupt line. The primary group holds a three-bit raw status vector (a software interrupt, an unused position and the combined request of the secondary group), a mask that is changed only through separate write-one-to-set and write-one-to-clear registers, and a masked status view. The host line is high whenever any masked bit is high. Raw status cannot be cleared from here, so software silences a source without touching it by clearing its mask bit.

The secondary group is a compatibility bank. It has sixteen handshake event flags and one system-status-change flag, all set by single-cycle pulses from their sources and cleared by writing ones. Each flag has its own enable. A global enable decides whether the bank's combined request reaches the primary group. The bank also reports an encoded vector naming the lowest-numbered enabled handshake cell that is pending.

Software drives the block through a plain register port: one write strobe with address and data, and a combinational read path. The event inputs and the host line are plain level/pulse pins with no handshake. This block has no streaming data, so there is no back-pressure.

Top module: `hirq_top`

## Requirements
- R1: Writing the mask-set register (address 1) sets each mask bit whose data bit is 1 and leaves bits written 0 unchanged; reading address 1 or address 2 returns the current three-bit mask.
- R2: Writing the mask-clear register (address 2) clears each mask bit whose data bit is 1 and leaves bits written 0 unchanged.
- R3: The raw register (address 0, read-only) shows the software interrupt state in bit 0, always 0 in bit 1, and the gated secondary-group request in bit 2; writes to it have no effect.
- R4: The masked register (address 3) equals raw AND mask, and irq_host is high exactly when that value is non-zero.
- R5: The software interrupt register (address 4) sets the state when bit 0 is written 1 and clears it when bit 8 is written 1; when both are 1 in one write, the state is cleared. A read returns the state in bit 0 and 0 in bit 8.
- R6: A handshake flag (bits 15:0 of the bank status register, address 5) is set by a pulse on hs_event and cleared by writing 1 to its bit, whether or not it is enabled; a pulse in the same cycle as the clear keeps the flag set.
- R7: Status bits 23:16 read 0x10+n where n is the lowest-numbered handshake cell both pending and enabled, and read 0x00 when no enabled cell is pending.
- R8: Status bit 31 is 1 when any enabled flag (handshake or system) is pending. It appears at raw bit 2 only while the global enable (bit 31 of the enable register, address 6) is 1; the per-source enables in bits 15:0 and 26 read back as written, independent of bit 31.
- R9: The system-status-change flag sits at bit 26 of the status register and its enable at bit 26 of the enable register; it is set by a pulse on sys_event and cleared by writing 1 to bit 26.
- R10: After reset every register reads 0 and irq_host is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (3) | Register address for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| hs_event | input | NUM_HS (16) | Single-cycle set pulses for the handshake flags |
| sys_event | input | 1 | Single-cycle set pulse for the system-status-change flag |
| irq_host | output | 1 | Combined host interrupt line |

## Verification
A wrong mask bit shows on the masked register and on irq_host in the cycle after the write that should have set or cleared it, but only when the matching raw bit is high, so the bench sweeps every raw pattern against every mask value. A lost or stuck handshake flag shows on the bank status read and on the vector directly after the pulse or the clear write. A wrong gating state shows on raw bit 2 and on irq_host one cycle after the enable write.

// File: rtl/hirq_pkg.sv
package hirq_pkg;
  localparam int DATA_W = 32;
  localparam int RAW_W  = 3;

  typedef enum logic [2:0] {
    A_RAW  = 3'd0,
    A_MSET = 3'd1,
    A_MCLR = 3'd2,
    A_MSKD = 3'd3,
    A_SWI  = 3'd4,
    A_HSST = 3'd5,
    A_HSEN = 3'd6
  } reg_addr_e;

  localparam int SW_SET_BIT = 0;
  localparam int SW_RST_BIT = 8;
  localparam int VEC_LSB    = 16;
  localparam int VEC_W      = 8;
  localparam int SYS_BIT    = 26;
  localparam int REQ_BIT    = 31;
  localparam int GEN_BIT    = 31;
  localparam int RAW_SW     = 0;
  localparam int RAW_FW     = 2;
  localparam logic [VEC_W-1:0] VEC_BASE = 8'h10;
endpackage

// File: rtl/hirq_mask_bank.sv
module hirq_mask_bank #(
  parameter int RAW_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic [RAW_W-1:0] wbits,
  input  logic [RAW_W-1:0] raw,
  output logic [RAW_W-1:0] mask_q,
  output logic [RAW_W-1:0] masked,
  output logic             irq
);
  logic [RAW_W-1:0] set_v, clr_v;

  assign set_v = set_we ? wbits : '0;
  assign clr_v = clr_we ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= (mask_q & ~clr_v) | set_v;
  end

  assign masked = raw & mask_q;
  assign irq    = |masked;
endmodule

// File: rtl/hirq_swirq.sv
module hirq_swirq (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic set_bit,
  input  logic rst_bit,
  output logic state_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               state_q <= 1'b0;
    else if (we && rst_bit)   state_q <= 1'b0;
    else if (we && set_bit)   state_q <= 1'b1;
  end
endmodule

// File: rtl/hirq_hs_bank.sv
module hirq_hs_bank
  import hirq_pkg::*;
#(
  parameter int NUM_HS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_HS-1:0] hs_event,
  input  logic              sys_event,
  input  logic              stat_we,
  input  logic              en_we,
  input  logic [NUM_HS-1:0] w_hs,
  input  logic              w_sys,
  input  logic              w_gen,
  output logic [NUM_HS-1:0] flags_q,
  output logic              sys_q,
  output logic [NUM_HS-1:0] en_q,
  output logic              sys_en_q,
  output logic              gen_q,
  output logic [VEC_W-1:0]  vector,
  output logic              req,
  output logic              fw_irq
);
  logic [NUM_HS-1:0] pend;

  for (genvar g = 0; g < NUM_HS; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q[g] <= 1'b0;
      else        flags_q[g] <= (flags_q[g] & ~(stat_we & w_hs[g])) | hs_event[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sys_q <= 1'b0;
    else        sys_q <= (sys_q & ~(stat_we & w_sys)) | sys_event;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      sys_en_q <= 1'b0;
      gen_q    <= 1'b0;
    end else if (en_we) begin
      en_q     <= w_hs;
      sys_en_q <= w_sys;
      gen_q    <= w_gen;
    end
  end

  assign pend = flags_q & en_q;

  always_comb begin
    vector = '0;
    for (int i = NUM_HS - 1; i >= 0; i--) begin
      if (pend[i]) vector = VEC_BASE + VEC_W'(i);
    end
  end

  assign req    = (|pend) | (sys_q & sys_en_q);
  assign fw_irq = req & gen_q;
endmodule

// File: rtl/hirq_top.sv
module hirq_top
  import hirq_pkg::*;
#(
  parameter int NUM_HS = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NUM_HS-1:0] hs_event,
  input  logic              sys_event,
  output logic              irq_host
);
  localparam int HS_PAD = VEC_LSB - NUM_HS;

  logic              we_mset, we_mclr, we_swi, we_hsst, we_hsen;
  logic [RAW_W-1:0]  raw_vec, mask_q, masked;
  logic              sw_q;
  logic [NUM_HS-1:0] hs_flags_q, hs_en_q;
  logic              sys_q, sys_en_q, hs_gen_q, hs_req, fw_irq;
  logic [VEC_W-1:0]  hs_vec;
  logic [31:0]       hsst_rd, hsen_rd;
  logic              wdata_unused;

  assign we_mset = reg_we && (reg_addr == ADDR_W'(A_MSET));
  assign we_mclr = reg_we && (reg_addr == ADDR_W'(A_MCLR));
  assign we_swi  = reg_we && (reg_addr == ADDR_W'(A_SWI));
  assign we_hsst = reg_we && (reg_addr == ADDR_W'(A_HSST));
  assign we_hsen = reg_we && (reg_addr == ADDR_W'(A_HSEN));

  hirq_swirq u_sw (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (we_swi),
    .set_bit (reg_wdata[SW_SET_BIT]),
    .rst_bit (reg_wdata[SW_RST_BIT]),
    .state_q (sw_q)
  );

  hirq_hs_bank #(.NUM_HS(NUM_HS)) u_hs (
    .clk      (clk),
    .rst_n    (rst_n),
    .hs_event (hs_event),
    .sys_event(sys_event),
    .stat_we  (we_hsst),
    .en_we    (we_hsen),
    .w_hs     (reg_wdata[NUM_HS-1:0]),
    .w_sys    (reg_wdata[SYS_BIT]),
    .w_gen    (reg_wdata[GEN_BIT]),
    .flags_q  (hs_flags_q),
    .sys_q    (sys_q),
    .en_q     (hs_en_q),
    .sys_en_q (sys_en_q),
    .gen_q    (hs_gen_q),
    .vector   (hs_vec),
    .req      (hs_req),
    .fw_irq   (fw_irq)
  );

  always_comb begin
    raw_vec         = '0;
    raw_vec[RAW_SW] = sw_q;
    raw_vec[RAW_FW] = fw_irq;
  end

  hirq_mask_bank #(.RAW_W(RAW_W)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_we (we_mset),
    .clr_we (we_mclr),
    .wbits  (reg_wdata[RAW_W-1:0]),
    .raw    (raw_vec),
    .mask_q (mask_q),
    .masked (masked),
    .irq    (irq_host)
  );

  always_comb begin
    hsst_rd                            = '0;
    hsst_rd[NUM_HS-1:0]                = hs_flags_q;
    hsst_rd[VEC_LSB +: VEC_W]          = hs_vec;
    hsst_rd[SYS_BIT]                   = sys_q;
    hsst_rd[REQ_BIT]                   = hs_req;
    hsen_rd                            = '0;
    hsen_rd[NUM_HS-1:0]                = hs_en_q;
    hsen_rd[SYS_BIT]                   = sys_en_q;
    hsen_rd[GEN_BIT]                   = hs_gen_q;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(A_RAW):  reg_rdata[RAW_W-1:0] = raw_vec;
      ADDR_W'(A_MSET),
      ADDR_W'(A_MCLR): reg_rdata[RAW_W-1:0] = mask_q;
      ADDR_W'(A_MSKD): reg_rdata[RAW_W-1:0] = masked;
      ADDR_W'(A_SWI):  reg_rdata[SW_SET_BIT] = sw_q;
      ADDR_W'(A_HSST): reg_rdata = hsst_rd;
      ADDR_W'(A_HSEN): reg_rdata = hsen_rd;
      default:         reg_rdata = '0;
    endcase
  end

  assign wdata_unused = ^{reg_wdata[SW_RST_BIT-1:NUM_HS > RAW_W ? SW_RST_BIT-1 : RAW_W],
                          reg_wdata[SYS_BIT-1:VEC_LSB], reg_wdata[GEN_BIT-1:SYS_BIT+1],
                          HS_PAD};
endmodule

module hirq_checker
  import hirq_pkg::*;
#(
  parameter int NUM_HS = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [NUM_HS-1:0] hs_event,
  input logic [RAW_W-1:0]  mask_q,
  input logic [RAW_W-1:0]  raw_vec,
  input logic              sw_q,
  input logic              hs_gen_q,
  input logic [NUM_HS-1:0] hs_flags_q,
  input logic              irq_host
);
  // R1
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(A_MSET)) |=>
      ((mask_q & $past(reg_wdata[RAW_W-1:0])) == $past(reg_wdata[RAW_W-1:0])));

  // R2
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(A_MCLR)) |=>
      ((mask_q & $past(reg_wdata[RAW_W-1:0])) == '0));

  // R4
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_host);

  // R5
  sw_reset_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(A_SWI) && reg_wdata[SW_RST_BIT]) |=> !sw_q);

  // R6
  hs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(A_HSST)) |=>
      ((hs_flags_q & $past(reg_wdata[NUM_HS-1:0] & ~hs_event)) == '0));

  // R8
  global_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_gen_q |-> !raw_vec[RAW_FW]);
endmodule

bind hirq_top hirq_checker #(.NUM_HS(NUM_HS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .hs_event  (hs_event),
  .mask_q    (mask_q),
  .raw_vec   (raw_vec),
  .sw_q      (sw_q),
  .hs_gen_q  (hs_gen_q),
  .hs_flags_q(hs_flags_q),
  .irq_host  (irq_host)
);

// File: tb/hirq_top_tb_top.sv
module hirq_top_tb_top;
  localparam int NHS = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] hs_event = '0;
  logic        sys_event = 1'b0;
  logic        irq_host;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hirq_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hs_event(hs_event),
    .sys_event(sys_event), .irq_host(irq_host)
  );

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic pulse(input logic [15:0] h, input logic s);
    @(negedge clk);
    hs_event = h; sys_event = s;
    @(negedge clk);
    hs_event = '0; sys_event = 1'b0;
  endtask

  function automatic logic [31:0] hs_exp(input logic [15:0] f, input logic s,
                                         input logic [15:0] e, input logic se);
    logic [15:0] p;
    logic [7:0]  vec;
    p = f & e;
    vec = 8'h00;
    for (int i = 15; i >= 0; i--) if (p[i]) vec = 8'h10 + 8'(i);
    return {(|p) | (s & se), 4'b0, s, 2'b0, vec, f};
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      chk(v, 32'h0, $sformatf("R10 reset reg %0d", a));
    end
    chk({31'b0, irq_host}, 32'h0, "R10 irq after reset");

    // R5 software interrupt set/reset
    wr(3'd4, 32'h1);    rd(3'd4, v); chk(v, 32'h1, "R5 set reads 1");
    rd(3'd0, v);        chk(v, 32'h1, "R3 raw bit0 follows sw");
    wr(3'd4, 32'h100);  rd(3'd4, v); chk(v, 32'h0, "R5 reset clears");
    wr(3'd4, 32'h1);    wr(3'd4, 32'h101); rd(3'd4, v); chk(v, 32'h0, "R5 both from 1 reset wins");
    wr(3'd4, 32'h101);  rd(3'd4, v); chk(v, 32'h0, "R5 both from 0 reset wins");

    // R1/R2 mask sweeps
    for (int m = 0; m < 8; m++) begin
      wr(3'd2, 32'h7); wr(3'd1, 32'(m));
      rd(3'd1, v); chk(v, 32'(m), "R1 mask set");
      wr(3'd1, 32'h0);
      rd(3'd2, v); chk(v, 32'(m), "R1 zero write no change");
      wr(3'd1, 32'h7); wr(3'd2, 32'(m));
      rd(3'd2, v); chk(v, 32'(7 & ~m), "R2 mask clear");
      wr(3'd2, 32'h0);
      rd(3'd1, v); chk(v, 32'(7 & ~m), "R2 zero write no change");
    end

    // R4/R3 raw x mask exhaustive
    pulse(16'h0001, 1'b0);
    for (int r = 0; r < 4; r++) begin
      logic [2:0] rawe;
      wr(3'd4, (r & 1) ? 32'h1 : 32'h100);
      wr(3'd6, (r & 2) ? 32'h8000_0001 : 32'h0000_0001);
      rawe = {r[1], 1'b0, r[0]};
      wr(3'd0, 32'hFFFF_FFFF);
      rd(3'd0, v); chk(v, 32'(rawe), "R3 raw pattern, write ignored");
      for (int m = 0; m < 8; m++) begin
        wr(3'd2, 32'h7); wr(3'd1, 32'(m));
        rd(3'd3, v); chk(v, 32'(rawe & 3'(m)), "R4 masked");
        chk({31'b0, irq_host}, {31'b0, |(rawe & 3'(m))}, "R4 irq line");
      end
    end
    wr(3'd5, 32'h0000_FFFF); wr(3'd4, 32'h100); wr(3'd2, 32'h7);

    // R7 single-cell sweep
    wr(3'd6, 32'h0000_FFFF);
    for (int n = 0; n < NHS; n++) begin
      pulse(16'(1 << n), 1'b0);
      rd(3'd5, v); chk(v, hs_exp(16'(1 << n), 1'b0, 16'hFFFF, 1'b0), "R7 single vector");
      wr(3'd5, 32'(1 << n));
      rd(3'd5, v); chk(v, 32'h0, "R6 clear single");
    end

    // R7 pair priority sweep
    for (int i = 0; i < NHS; i++) begin
      for (int j = i + 1; j < NHS; j++) begin
        logic [15:0] pr;
        pr = 16'((1 << i) | (1 << j));
        pulse(pr, 1'b0);
        rd(3'd5, v); chk(v[23:16], 32'(8'h10 + 8'(i)), "R7 lowest wins");
        wr(3'd5, 32'(pr));
      end
    end

    // R7/R6 disabled pending, clear while disabled
    wr(3'd6, 32'h0000_FFFE);
    pulse(16'h0021, 1'b0);
    rd(3'd5, v); chk(v, hs_exp(16'h0021, 1'b0, 16'hFFFE, 1'b0), "R7 disabled cell skipped");
    wr(3'd5, 32'h1);
    rd(3'd5, v); chk(v, hs_exp(16'h0020, 1'b0, 16'hFFFE, 1'b0), "R6 clear while disabled");
    wr(3'd5, 32'h20);
    wr(3'd6, 32'h0);
    pulse(16'h0004, 1'b0);
    rd(3'd5, v); chk(v, hs_exp(16'h0004, 1'b0, 16'h0, 1'b0), "R7 none enabled vector 0");
    wr(3'd5, 32'h4);

    // R6 event and clear in the same cycle
    pulse(16'h0008, 1'b0);
    @(negedge clk);
    hs_event = 16'h0008; reg_we = 1'b1; reg_addr = 3'd5; reg_wdata = 32'h8;
    @(negedge clk);
    hs_event = '0; reg_we = 1'b0; reg_wdata = '0;
    rd(3'd5, v); chk(v[15:0], 32'h8, "R6 event beats clear");
    wr(3'd5, 32'h8);

    // R8 global gate
    wr(3'd1, 32'h4);
    wr(3'd6, 32'h0000_0100);
    pulse(16'h0100, 1'b0);
    rd(3'd5, v); chk(v[31], 32'h1, "R8 request bit");
    rd(3'd0, v); chk(v, 32'h0, "R8 gate closed raw bit2 low");
    chk({31'b0, irq_host}, 32'h0, "R8 gate closed irq low");
    wr(3'd6, 32'h8000_0100);
    rd(3'd0, v); chk(v, 32'h4, "R8 gate open raw bit2");
    chk({31'b0, irq_host}, 32'h1, "R8 gate open irq");
    rd(3'd6, v); chk(v, 32'h8000_0100, "R8 enables read back");
    wr(3'd6, 32'h0000_0100);
    rd(3'd6, v); chk(v, 32'h0000_0100, "R8 per-source enables kept");
    wr(3'd5, 32'h100);

    // R9 system flag
    wr(3'd6, 32'h8400_0000);
    pulse(16'h0, 1'b1);
    rd(3'd5, v); chk(v, hs_exp(16'h0, 1'b1, 16'h0, 1'b1), "R9 sys flag sets req, vector 0");
    chk({31'b0, irq_host}, 32'h1, "R9 sys reaches irq");
    wr(3'd5, 32'h0400_0000);
    rd(3'd5, v); chk(v, 32'h0, "R9 sys flag cleared");
    chk({31'b0, irq_host}, 32'h0, "R9 irq drops");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule